// File: doc/BRIEF.md
# Per-Thread Write-Combining Store Queue

This block buffers stores in front of a shared second-level cache for a write-through first-level data cache. Each hardware thread owns one queue slot, and the slot holds a whole 64-byte line with one mask bit per byte. A store arrives with a physical byte address, a size code and data. The block shifts the store into place inside its line and sets only the mask bits the store covers. A later store from the same thread to the same line merges into the slot until the cache accepts the request for that slot. Filled slots go to the cache as line-wide write requests, one at a time, in the order the slots were first filled. A request waits on a valid/acknowledge handshake. The slot is released when a response carrying the thread's identifier arrives.

When the data cache hits on a load, the block returns the bytes that the loading thread still has queued for that line, with a mask that marks which of them are valid. Bytes queued by other threads are never returned. When a store cannot be accepted, the block asks the pipeline to roll back and suspend the thread. This happens when the slot holds another line, or when the slot has already been handed to the cache. A memory barrier also suspends the thread while its slot is occupied. The cache response that frees the slot wakes the thread. Stores never ask for a line to be loaded into the first-level cache.

Top module: `store_combine_queue`

## Requirements
- R1: After reset, `req_valid`, `st_rollback`, `bar_suspend` and `wake` are low, and `fwd_mask` is zero for any load.
- R2: `st_size` gives log2 of the byte count (0=1, 1=2, 2=4, 3=8, 6 or more = 64 bytes). The store is placed at byte offset `st_addr[5:0]`, rounded down to a multiple of its size. Exactly that many mask bits are set from that offset, and data byte k of `st_data` lands in line byte offset+k.
- R3: A store from a thread whose slot holds the same line and has not been acknowledged merges into the slot. Its bytes overwrite the queued bytes, its mask is ORed in, no rollback is raised and no extra request is made.
- R4: A store from a thread whose slot holds a different line raises `st_rollback` in the same cycle and leaves the slot unchanged.
- R5: After `req_ack` has been sampled high for a slot, a store to that same line from that thread raises `st_rollback`.
- R6: Requests are presented in the order the slots were filled, across threads. Merging into a slot does not change its place.
- R7: A request shows `req_id` = thread, `req_addr` = line address `addr[31:6]` and the slot's data and mask. `req_valid`, `req_id` and `req_addr` hold until `req_ack` is sampled high.
- R8: `rsp_valid` with `rsp_id` = t frees slot t, and thread t's next store is accepted into an empty slot.
- R9: With `ld_valid`, `fwd_mask` and `fwd_data` show the slot of `ld_thread` when it holds line `ld_line`, whether or not it has been sent. Otherwise `fwd_mask` is zero.
- R10: `wake[t]` pulses in the cycle of the response that frees slot t, if thread t was rolled back or barrier-suspended since the slot was filled. Otherwise it stays low.
- R11: `bar_valid` raises `bar_suspend` in the same cycle when the slot of `bar_thread` is occupied, and leaves it low when the slot is empty.
- R12: A store that merges into the slot being acknowledged in that same cycle is refused with `st_rollback`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store present |
| st_thread | input | TID_W | Storing thread |
| st_addr | input | ADDR_W | Physical byte address of the store |
| st_size | input | 3 | log2 of store size in bytes |
| st_data | input | 512 | Store data, low bytes first |
| st_rollback | output | 1 | Store refused; roll back and suspend thread |
| ld_valid | input | 1 | Load hit lookup present |
| ld_thread | input | TID_W | Loading thread |
| ld_line | input | ADDR_W-6 | Line address of the load |
| fwd_mask | output | 64 | Bytes supplied by the queue |
| fwd_data | output | 512 | Queued line data |
| bar_valid | input | 1 | Memory barrier present |
| bar_thread | input | TID_W | Thread executing the barrier |
| bar_suspend | output | 1 | Barrier must suspend the thread |
| req_valid | output | 1 | Line write request to the cache |
| req_id | output | TID_W | Thread identifier of the request |
| req_addr | output | ADDR_W-6 | Line address of the request |
| req_data | output | 512 | Line data of the request |
| req_mask | output | 64 | Byte mask of the request |
| req_ack | input | 1 | Cache accepted the request |
| rsp_valid | input | 1 | Cache finished a request |
| rsp_id | input | TID_W | Thread identifier of the finished request |
| wake | output | NUM_THREADS | Per-thread resume pulse |

## Verification
Suppose a slot's sent flag is lost or set early. Then a store after the acknowledge would merge silently instead of rolling back, or a legal merge would be refused. Either shows on `st_rollback` in the cycle of that store. A corrupted send-order queue presents the wrong `req_id` right after the next acknowledge. A dropped wait flag shows up only at the freeing response, as a missing `wake` pulse. A misplaced byte shows at once on `req_mask`/`req_data` and on the forwarded line.

// File: rtl/sq_pkg.sv
package sq_pkg;
    localparam int LINE_BYTES = 64;
    localparam int LINE_BITS  = LINE_BYTES * 8;
    localparam int OFF_W      = $clog2(LINE_BYTES);
    localparam int SIZE_W     = 3;

    typedef struct packed {
        logic [LINE_BITS-1:0]  data;
        logic [LINE_BYTES-1:0] mask;
    } line_t;

    function automatic logic [OFF_W:0] size_bytes(input logic [SIZE_W-1:0] sz);
        logic [OFF_W:0] n;
        if (sz >= SIZE_W'(OFF_W)) n = (OFF_W+1)'(LINE_BYTES);
        else                       n = (OFF_W+1)'(1) << sz;
        return n;
    endfunction

    function automatic line_t place_store(input logic [OFF_W-1:0] off,
                                          input logic [SIZE_W-1:0] sz,
                                          input logic [LINE_BITS-1:0] raw);
        line_t r;
        logic [OFF_W:0]   n;
        logic [OFF_W-1:0] base;
        n    = size_bytes(sz);
        base = off & ~OFF_W'(n - 1'b1);
        for (int b = 0; b < LINE_BYTES; b++) begin
            r.mask[b] = (b >= int'(base)) && (b < int'(base) + int'(n));
            r.data[b*8 +: 8] = r.mask[b] ? raw[(b - int'(base))*8 +: 8] : 8'h00;
        end
        return r;
    endfunction
endpackage

// File: rtl/sq_order.sv
module sq_order #(
    parameter int DEPTH = 4,
    parameter int ID_W  = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            push,
    input  logic [ID_W-1:0] push_id,
    input  logic            pop,
    output logic            nonempty,
    output logic [ID_W-1:0] head_id
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [ID_W-1:0]  slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                slots[wr_ptr] <= push_id;
                wr_ptr        <= bump(wr_ptr);
            end
            if (pop) rd_ptr <= bump(rd_ptr);
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end

    assign nonempty = (count != '0);
    assign head_id  = slots[rd_ptr];
endmodule

// File: rtl/sq_slot.sv
module sq_slot
    import sq_pkg::*;
#(
    parameter int LADDR_W = 26
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fill,
    input  logic               combine,
    input  logic [LADDR_W-1:0] new_line,
    input  line_t              new_bytes,
    input  logic               mark_sent,
    input  logic               release_slot,
    output logic               busy,
    output logic               sent,
    output logic [LADDR_W-1:0] line,
    output line_t              content
);
    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            sent    <= 1'b0;
            line    <= '0;
            content <= '0;
        end else begin
            if (release_slot) begin
                busy <= 1'b0;
                sent <= 1'b0;
            end else if (fill) begin
                busy    <= 1'b1;
                sent    <= 1'b0;
                line    <= new_line;
                content <= new_bytes;
            end else begin
                if (mark_sent) sent <= 1'b1;
                if (combine) begin
                    content.mask <= content.mask | new_bytes.mask;
                    for (int b = 0; b < LINE_BYTES; b++)
                        if (new_bytes.mask[b])
                            content.data[b*8 +: 8] <= new_bytes.data[b*8 +: 8];
                end
            end
        end
    end
endmodule

// File: rtl/store_combine_queue.sv
module store_combine_queue
    import sq_pkg::*;
#(
    parameter int NUM_THREADS = 4,
    parameter int ADDR_W      = 32,
    localparam int TID_W      = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1,
    localparam int LADDR_W    = ADDR_W - OFF_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   st_valid,
    input  logic [TID_W-1:0]       st_thread,
    input  logic [ADDR_W-1:0]      st_addr,
    input  logic [SIZE_W-1:0]      st_size,
    input  logic [LINE_BITS-1:0]   st_data,
    output logic                   st_rollback,
    input  logic                   ld_valid,
    input  logic [TID_W-1:0]       ld_thread,
    input  logic [LADDR_W-1:0]     ld_line,
    output logic [LINE_BYTES-1:0]  fwd_mask,
    output logic [LINE_BITS-1:0]   fwd_data,
    input  logic                   bar_valid,
    input  logic [TID_W-1:0]       bar_thread,
    output logic                   bar_suspend,
    output logic                   req_valid,
    output logic [TID_W-1:0]       req_id,
    output logic [LADDR_W-1:0]     req_addr,
    output logic [LINE_BITS-1:0]   req_data,
    output logic [LINE_BYTES-1:0]  req_mask,
    input  logic                   req_ack,
    input  logic                   rsp_valid,
    input  logic [TID_W-1:0]       rsp_id,
    output logic [NUM_THREADS-1:0] wake
);
    logic [NUM_THREADS-1:0] ent_valid, ent_sent, fill_v, held;
    logic [LADDR_W-1:0]     ent_line [NUM_THREADS];
    line_t                  ent_body [NUM_THREADS];

    line_t              placed;
    logic [LADDR_W-1:0] st_line;
    logic               ack_fire, ack_hits_st, can_fill, can_merge, any_fill;
    logic [TID_W-1:0]   head_id, fill_id;

    assign st_line     = st_addr[ADDR_W-1:OFF_W];
    assign placed      = place_store(st_addr[OFF_W-1:0], st_size, st_data);
    assign ack_fire    = req_valid && req_ack;
    assign ack_hits_st = ack_fire && (head_id == st_thread);
    assign can_fill    = !ent_valid[st_thread];
    assign can_merge   = ent_valid[st_thread] && !ent_sent[st_thread]
                         && (ent_line[st_thread] == st_line) && !ack_hits_st;
    assign st_rollback = st_valid && !can_fill && !can_merge;
    assign bar_suspend = bar_valid && ent_valid[bar_thread];
    assign any_fill    = st_valid && can_fill;
    assign fill_id     = st_thread;

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_slot
        logic hit_t, free_t, park_t;
        assign hit_t  = (st_thread == TID_W'(t));
        assign free_t = rsp_valid && (rsp_id == TID_W'(t)) && ent_valid[t];
        assign park_t = (st_rollback && hit_t)
                        || (bar_suspend && (bar_thread == TID_W'(t)));
        assign fill_v[t] = st_valid && hit_t && can_fill;
        assign wake[t]   = free_t && (held[t] || park_t);

        sq_slot #(.LADDR_W(LADDR_W)) i_slot (
            .clk          (clk),
            .rst          (rst),
            .fill         (fill_v[t]),
            .combine      (st_valid && hit_t && can_merge),
            .new_line     (st_line),
            .new_bytes    (placed),
            .mark_sent    (ack_fire && (head_id == TID_W'(t))),
            .release_slot (free_t),
            .busy         (ent_valid[t]),
            .sent         (ent_sent[t]),
            .line         (ent_line[t]),
            .content      (ent_body[t])
        );

        always_ff @(posedge clk) begin
            if (rst)         held[t] <= 1'b0;
            else if (free_t) held[t] <= 1'b0;
            else if (park_t) held[t] <= 1'b1;
        end
    end

    sq_order #(.DEPTH(NUM_THREADS), .ID_W(TID_W)) i_order (
        .clk      (clk),
        .rst      (rst),
        .push     (any_fill),
        .push_id  (fill_id),
        .pop      (ack_fire),
        .nonempty (req_valid),
        .head_id  (head_id)
    );

    assign req_id   = head_id;
    assign req_addr = ent_line[head_id];
    assign req_data = ent_body[head_id].data;
    assign req_mask = ent_body[head_id].mask;

    always_comb begin
        fwd_mask = '0;
        fwd_data = '0;
        if (ld_valid && ent_valid[ld_thread] && (ent_line[ld_thread] == ld_line)) begin
            fwd_mask = ent_body[ld_thread].mask;
            fwd_data = ent_body[ld_thread].data;
        end
    end
endmodule

// File: rtl/sq_checker.sv
module sq_checker #(
    parameter int NT    = 4,
    parameter int TID_W = 2,
    parameter int LA_W  = 26
) (
    input logic             clk,
    input logic             rst,
    input logic             st_valid,
    input logic             st_rollback,
    input logic             ld_valid,
    input logic [63:0]      fwd_mask,
    input logic             bar_valid,
    input logic [TID_W-1:0] bar_thread,
    input logic             bar_suspend,
    input logic             req_valid,
    input logic             req_ack,
    input logic [TID_W-1:0] req_id,
    input logic [LA_W-1:0]  req_addr,
    input logic             rsp_valid,
    input logic [TID_W-1:0] rsp_id,
    input logic [NT-1:0]    wake,
    input logic [NT-1:0]    ent_valid,
    input logic [NT-1:0]    ent_sent
);
    p_held_request_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ack) |=> (req_valid && $stable(req_id) && $stable(req_addr)));

    p_ack_marks_sent_r5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ack && !(rsp_valid && rsp_id == req_id))
        |=> ent_sent[$past(req_id)]);

    p_rollback_needs_store_r4: assert property (@(posedge clk) disable iff (rst)
        st_rollback |-> st_valid);

    p_barrier_only_busy_r11: assert property (@(posedge clk) disable iff (rst)
        bar_suspend |-> (bar_valid && ent_valid[bar_thread]));

    p_single_wake_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wake));

    p_wake_needs_rsp_r10: assert property (@(posedge clk) disable iff (rst)
        (wake != '0) |-> rsp_valid);

    p_no_fwd_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !ld_valid |-> (fwd_mask == '0));
endmodule

bind store_combine_queue sq_checker #(
    .NT(NUM_THREADS), .TID_W(TID_W), .LA_W(LADDR_W)
) i_sq_checker (
    .clk(clk), .rst(rst), .st_valid(st_valid), .st_rollback(st_rollback),
    .ld_valid(ld_valid), .fwd_mask(fwd_mask), .bar_valid(bar_valid),
    .bar_thread(bar_thread), .bar_suspend(bar_suspend), .req_valid(req_valid),
    .req_ack(req_ack), .req_id(req_id), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_id(rsp_id), .wake(wake),
    .ent_valid(ent_valid), .ent_sent(ent_sent)
);

// File: tb/test_store_combine_queue.sv
module test_store_combine_queue;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         st_valid = 0, ld_valid = 0, bar_valid = 0, req_ack = 0, rsp_valid = 0;
    logic [1:0]   st_thread = 0, ld_thread = 0, bar_thread = 0, rsp_id = 0;
    logic [31:0]  st_addr = 0;
    logic [2:0]   st_size = 0;
    logic [511:0] st_data = '0;
    logic [25:0]  ld_line = 0;
    logic         st_rollback, bar_suspend, req_valid;
    logic [63:0]  fwd_mask, req_mask;
    logic [511:0] fwd_data, req_data;
    logic [1:0]   req_id;
    logic [25:0]  req_addr;
    logic [3:0]   wake;
    int total = 0, bad = 0;

    always #10 clk = ~clk;

    store_combine_queue i_store_combine_queue (.*);

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic store(input logic [1:0] t, input logic [31:0] a, input logic [2:0] sz,
                         input logic [511:0] d, input logic exp_rb, input string req);
        @(negedge clk);
        st_valid = 1; st_thread = t; st_addr = a; st_size = sz; st_data = d;
        #1 chk(req, 64'(st_rollback), 64'(exp_rb));
        @(posedge clk); #1 st_valid = 0;
    endtask

    task automatic ack();
        @(negedge clk); req_ack = 1;
        @(posedge clk); #1 req_ack = 0;
    endtask

    task automatic respond(input logic [1:0] t, input logic [3:0] exp_wake, input string req);
        @(negedge clk); rsp_valid = 1; rsp_id = t;
        #1 chk(req, 64'(wake), 64'(exp_wake));
        @(posedge clk); #1 rsp_valid = 0;
    endtask

    typedef struct packed {
        logic [5:0]  off;
        logic [2:0]  sz;
        logic [5:0]  lo;
        logic [63:0] mask;
    } vec_t;
    localparam vec_t VECS [7] = '{
        '{6'd0,  3'd0, 6'd0,  64'h0000_0000_0000_0001},
        '{6'd5,  3'd0, 6'd5,  64'h0000_0000_0000_0020},
        '{6'd6,  3'd1, 6'd6,  64'h0000_0000_0000_00C0},
        '{6'd7,  3'd1, 6'd6,  64'h0000_0000_0000_00C0},
        '{6'd12, 3'd2, 6'd12, 64'h0000_0000_0000_F000},
        '{6'd8,  3'd3, 6'd8,  64'h0000_0000_0000_FF00},
        '{6'd0,  3'd6, 6'd0,  64'hFFFF_FFFF_FFFF_FFFF}
    };

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        ld_valid = 1; ld_thread = 0; ld_line = 0;
        #1;
        chk("R1 req_valid", 64'(req_valid), 0);
        chk("R1 fwd_mask", fwd_mask, 0);
        chk("R1 rollback", 64'(st_rollback), 0);
        chk("R1 wake", 64'(wake), 0);
        ld_valid = 0;

        // R2 alignment table, thread 0
        foreach (VECS[k]) begin
            store(2'd0, {26'h100 + 26'(k), VECS[k].off}, VECS[k].sz,
                  {{63{8'h77}}, 8'h30 + 8'(k)}, 1'b0, "R2 accept");
            @(negedge clk);
            chk("R2 mask", req_mask, VECS[k].mask);
            chk("R2 data byte", 64'(req_data[VECS[k].lo*8 +: 8]), 64'(8'h30 + 8'(k)));
            chk("R7 addr", 64'(req_addr), 64'(26'h100 + 26'(k)));
            ack();
            respond(2'd0, 4'b0000, "R10 no wake when not held");
        end

        // R3 merge on thread 1, line 0x200
        store(2'd1, {26'h200, 6'd0}, 3'd2, 512'hDDCCBBAA, 1'b0, "R3 first");
        store(2'd1, {26'h200, 6'd1}, 3'd0, 512'h55, 1'b0, "R3 merge accepted");
        @(negedge clk);
        chk("R3 merged mask", req_mask, 64'hF);
        chk("R3 merged data", 64'(req_data[31:0]), 64'hDDCC55AA);
        chk("R7 id", 64'(req_id), 1);

        // R9 forwarding
        ld_valid = 1; ld_thread = 1; ld_line = 26'h200;
        #1 chk("R9 own thread mask", fwd_mask, 64'hF);
        chk("R9 own thread data", 64'(fwd_data[31:0]), 64'hDDCC55AA);
        ld_thread = 2;
        #1 chk("R9 other thread", fwd_mask, 0);
        ld_valid = 0;

        // R4 different line
        store(2'd1, {26'h201, 6'd0}, 3'd0, 512'h1, 1'b1, "R4 other line rollback");
        @(negedge clk);
        chk("R4 slot unchanged", 64'(req_addr), 64'h200);

        // R6 order: thread 2 then thread 0 queue behind thread 1
        store(2'd2, {26'h300, 6'd0}, 3'd0, 512'h11, 1'b0, "R6 t2 fill");
        store(2'd0, {26'h400, 6'd0}, 3'd0, 512'h22, 1'b0, "R6 t0 fill");
        store(2'd1, {26'h200, 6'd4}, 3'd0, 512'h66, 1'b0, "R6 merge head");
        @(negedge clk);
        chk("R7 held id", 64'(req_id), 1);
        ack();
        @(negedge clk);
        chk("R6 second request", 64'(req_id), 2);
        store(2'd1, {26'h200, 6'd2}, 3'd0, 512'h9, 1'b1, "R5 merge after ack");
        ld_valid = 1; ld_thread = 1; ld_line = 26'h200;
        #1 chk("R9 forward while sent", fwd_mask, 64'h1F);
        ld_valid = 0;

        // R11 barrier
        @(negedge clk);
        bar_valid = 1; bar_thread = 1;
        #1 chk("R11 busy suspend", 64'(bar_suspend), 1);
        bar_thread = 3;
        #1 chk("R11 empty no suspend", 64'(bar_suspend), 0);
        bar_valid = 0;

        // R8/R10 free and wake thread 1
        respond(2'd1, 4'b0010, "R10 wake held thread");
        store(2'd1, {26'h500, 6'd0}, 3'd0, 512'h3, 1'b0, "R8 refill after free");

        // R12 merge refused on the ack cycle of thread 2
        @(negedge clk);
        chk("R6 head still t2", 64'(req_id), 2);
        req_ack = 1;
        st_valid = 1; st_thread = 2; st_addr = {26'h300, 6'd1}; st_size = 0; st_data = 512'h4;
        #1 chk("R12 merge on ack cycle", 64'(st_rollback), 1);
        @(posedge clk); #1 req_ack = 0; st_valid = 0;
        @(negedge clk);
        chk("R6 third request", 64'(req_id), 0);
        chk("R6 third addr", 64'(req_addr), 64'h400);
        respond(2'd2, 4'b0100, "R10 wake after R12 rollback");
        ack();
        @(negedge clk);
        chk("R6 fourth request", 64'(req_id), 1);
        respond(2'd0, 4'b0000, "R10 no wake t0");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule